// File: doc/BRIEF.md
# Fast-Startup Wake-Up Controller

This block stops the system clock on command and restarts it when a selected wake-up condition appears. Software requests the stop with a keyed write to the oscillator control register that sets the wait command bit. From the next edge the block drops the system clock enable and also drops the RC oscillator enable, so every clock in the system is off. Eleven external wake-up pins and five internal event lines are brought in through a two-stage synchroniser. After that they are combined without further registers, so detection does not depend on the gated clock.

When any enabled source reaches its programmed level, the block raises the RC oscillator enable. It then waits for the oscillator model to report ready, gives the clock back, clears the wait bit and sets the master-clock-ready status. The control register also holds the crystal enable and the main source select. A change of the source select clears a completion flag, which returns after a fixed settling time. The block also keeps the wake-up enable register and the wake-up polarity register, both readable over the register bus.

Top module: `fsw_ctrl`

## Requirements
- R1: A write to the control register (offset 0x10) changes nothing unless bits 23:16 of the write data equal 0x37. Crystal enable (bit 0), wait command (bit 2) and source select (bit 24) all keep their values.
- R2: A keyed control write with bit 2 set, while no enabled wake-up source is active, enters the wait state at the next edge. In that state `clk_en` and `rc_osc_en` are low, control bit 2 reads 1 and status (offset 0x14) bit 1 reads 0.
- R3: The wake-up enable register (offset 0x70) holds pin enables in bits 10:0. It holds internal event enables at bit 17 (`wk_evt[0]`), 18 (`wk_evt[1]`), 19 (`wk_evt[2]`), 24 (`wk_evt[3]`) and 25 (`wk_evt[4]`). All other bits read 0, so a write of all ones reads back 0x030E07FF.
- R4: The polarity register (offset 0x74) holds one bit per pin in bits 10:0, where 1 means active high and 0 means active low. Other bits read 0. Internal events are always active high.
- R5: `wake_req` is high two clock edges after an input change exactly when at least one enabled source is at its active level. Disabled sources have no effect.
- R6: In the wait state an active wake request raises `rc_osc_en` at the next edge. `clk_en` stays low for as long as `rc_ready` is low.
- R7: With `rc_ready` high in the restart state, the next edge sets `clk_en` high, clears control bit 2 and sets status bit 1.
- R8: A wait command written while a wake request is already active is dropped. `clk_en` stays high and control bit 2 reads 0.
- R9: Changing control bit 24 clears status bit 0, which returns to 1 SEL_LAT edges after the write edge. Control bit 0 drives `xtal_en` and bit 24 drives `main_src_xtal`.
- R10: While the clock is stopped (wait or restart state), register writes are ignored.
- R11: After reset `clk_en` and `rc_osc_en` are high, control, enable and polarity registers read 0, and status reads 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wk_pin | input | 11 | Raw external wake-up pins |
| wk_evt | input | 5 | Raw internal wake-up events, active high |
| rc_ready | input | 1 | RC oscillator ready from the analog model |
| clk_en | output | 1 | System clock enable |
| rc_osc_en | output | 1 | RC oscillator enable / restart request |
| xtal_en | output | 1 | Crystal oscillator enable |
| main_src_xtal | output | 1 | Main clock source: 1 crystal, 0 RC |
| wake_req | output | 1 | Combined wake-up request |

## Verification
Two functions can meet in one cycle: the keyed wait command and an enabled wake-up source that is already active. The bench provokes this by holding an enabled active-high pin high, then writing the wait command. It expects the clock enable never to drop and the wait bit to read back as 0. A second collision is tested too: a register write arrives while the clock is stopped. The bench expects the enable register to read back unchanged once the block has woken up.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    parameter int unsigned NUM_PINS = 11;
    parameter int unsigned NUM_EVT  = 5;
    parameter int unsigned DATA_W   = 32;
    parameter int unsigned ADDR_W   = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WKEN = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_WKPOL = 8'h74;

    // control register layout
    localparam int unsigned BIT_XTAL = 0;
    localparam int unsigned BIT_WAIT = 2;
    localparam int unsigned KEY_LSB  = 16;
    localparam int unsigned KEY_MSB  = 23;
    localparam int unsigned BIT_SEL  = 24;
    localparam logic [7:0]  CTRL_KEY = 8'h37;

    // status register layout
    localparam int unsigned STAT_SEL_DONE = 0;
    localparam int unsigned STAT_MCK_RDY  = 1;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_WAIT    = 2'd1,
        PS_RESTART = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic [NUM_EVT-1:0]  evt;
        logic [NUM_PINS-1:0] pin;
    } wake_src_t;

    // enable-register bit position of internal event i
    function automatic int unsigned evt_pos(int unsigned i);
        case (i)
            0:       return 17;
            1:       return 18;
            2:       return 19;
            3:       return 24;
            default: return 25;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wken_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(NUM_PINS); i++) m[i] = 1'b1;
        for (int j = 0; j < int'(NUM_EVT); j++) m[evt_pos(j)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/fsw_sync.sv
module fsw_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fsw_wake_detect.sv
module fsw_wake_detect
    import fsw_pkg::*;
(
    input  logic [NUM_PINS-1:0] pin,
    input  logic [NUM_PINS-1:0] pin_en,
    input  logic [NUM_PINS-1:0] pin_pol,
    input  logic [NUM_EVT-1:0]  evt,
    input  logic [NUM_EVT-1:0]  evt_en,
    output logic                hit
);
    logic [NUM_PINS-1:0] pin_active;

    // pin at its programmed level: equal to the polarity bit
    always_comb begin
        pin_active = pin ~^ pin_pol;
        hit = (|(pin_active & pin_en)) | (|(evt & evt_en));
    end
endmodule

// File: rtl/fsw_regs.sv
module fsw_regs
    import fsw_pkg::*;
#(
    parameter int unsigned SEL_LAT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_allow,
    input  logic                wait_flag,
    input  logic                mck_rdy,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_PINS-1:0] pin_en,
    output logic [NUM_PINS-1:0] pin_pol,
    output logic [NUM_EVT-1:0]  evt_en,
    output logic                xtal_en,
    output logic                main_sel,
    output logic                wait_cmd
);
    localparam int unsigned       CNT_W   = $clog2(SEL_LAT + 1);
    localparam logic [DATA_W-1:0] EN_MASK = wken_mask();

    logic [DATA_W-1:0]   en_q;
    logic [NUM_PINS-1:0] pol_q;
    logic                xtal_q, sel_q, sel_done_q;
    logic [CNT_W-1:0]    sel_cnt;
    logic                key_ok, ctrl_wr, en_wr, pol_wr;

    always_comb begin
        key_ok   = (wdata[KEY_MSB:KEY_LSB] == CTRL_KEY);
        ctrl_wr  = wr_en && wr_allow && (addr == OFS_CTRL) && key_ok;
        en_wr    = wr_en && wr_allow && (addr == OFS_WKEN);
        pol_wr   = wr_en && wr_allow && (addr == OFS_WKPOL);
        wait_cmd = ctrl_wr && wdata[BIT_WAIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            pol_q      <= '0;
            xtal_q     <= 1'b0;
            sel_q      <= 1'b0;
            sel_done_q <= 1'b1;
            sel_cnt    <= '0;
        end else begin
            if (en_wr)  en_q  <= wdata & EN_MASK;
            if (pol_wr) pol_q <= wdata[NUM_PINS-1:0];
            if (ctrl_wr) begin
                xtal_q <= wdata[BIT_XTAL];
                sel_q  <= wdata[BIT_SEL];
            end
            if (ctrl_wr && (wdata[BIT_SEL] != sel_q)) begin
                sel_cnt    <= CNT_W'(SEL_LAT);
                sel_done_q <= 1'b0;
            end else if (sel_cnt != '0) begin
                sel_cnt    <= sel_cnt - CNT_W'(1);
                sel_done_q <= (sel_cnt == CNT_W'(1));
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[BIT_XTAL] = xtal_q;
                rdata[BIT_WAIT] = wait_flag;
                rdata[BIT_SEL]  = sel_q;
            end
            OFS_STAT: begin
                rdata[STAT_SEL_DONE] = sel_done_q;
                rdata[STAT_MCK_RDY]  = mck_rdy;
            end
            OFS_WKEN:  rdata = en_q;
            OFS_WKPOL: rdata[NUM_PINS-1:0] = pol_q;
            default:   rdata = '0;
        endcase
    end

    assign pin_en   = en_q[NUM_PINS-1:0];
    assign pin_pol  = pol_q;
    assign xtal_en  = xtal_q;
    assign main_sel = sel_q;

    for (genvar g = 0; g < int'(NUM_EVT); g++) begin : g_evt_en
        assign evt_en[g] = en_q[evt_pos(g)];
    end

    // R1: control write with a wrong key leaves crystal and select untouched
    a_r1_key_guard: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && !key_ok) |=> ($stable(xtal_q) && $stable(sel_q)))
        else $error("a_r1_key_guard");

    // R9: a source-select change is never reported complete in its own cycle
    a_r9_sel_pending: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel_q) || $fell(sel_q)) |-> !sel_done_q)
        else $error("a_r9_sel_pending");

    // R10: no register changes while the clock is stopped
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !wr_allow |=> ($stable(en_q) && $stable(pol_q)))
        else $error("a_r10_frozen");
endmodule

// File: rtl/fsw_pwr_fsm.sv
module fsw_pwr_fsm
    import fsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wait_cmd,
    input  logic wake_hit,
    input  logic rc_ready,
    output logic clk_en,
    output logic rc_osc_en,
    output logic wait_flag,
    output logic mck_rdy,
    output logic run
);
    pwr_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_RUN;
            mck_rdy <= 1'b1;
        end else begin
            case (state)
                PS_RUN: if (wait_cmd && !wake_hit) begin
                    state   <= PS_WAIT;
                    mck_rdy <= 1'b0;
                end
                PS_WAIT: if (wake_hit) state <= PS_RESTART;
                PS_RESTART: if (rc_ready) begin
                    state   <= PS_RUN;
                    mck_rdy <= 1'b1;
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    always_comb begin
        run       = (state == PS_RUN);
        clk_en    = run;
        rc_osc_en = (state != PS_WAIT);
        wait_flag = !run;
    end

    // R2: the clock only stops after an accepted wait command
    a_r2_entry_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> $past(wait_cmd && !wake_hit))
        else $error("a_r2_entry_needs_cmd");

    // R6: wake in the wait state restarts the RC oscillator, clock still off
    a_r6_wake_restarts: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAIT && wake_hit) |=> (rc_osc_en && !clk_en))
        else $error("a_r6_wake_restarts");

    // R7: oscillator ready returns the clock and the ready status
    a_r7_ready_resumes: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RESTART && rc_ready) |=> (clk_en && mck_rdy))
        else $error("a_r7_ready_resumes");

    // R8: wait command with an active wake request is dropped
    a_r8_abort_entry: assert property (@(posedge clk) disable iff (rst)
        (clk_en && wait_cmd && wake_hit) |=> clk_en)
        else $error("a_r8_abort_entry");
endmodule

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
    import fsw_pkg::*;
#(
    parameter int unsigned SEL_LAT     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] wk_pin,
    input  logic [NUM_EVT-1:0]  wk_evt,
    input  logic                rc_ready,
    output logic                clk_en,
    output logic                rc_osc_en,
    output logic                xtal_en,
    output logic                main_src_xtal,
    output logic                wake_req
);
    localparam int unsigned SRC_W = NUM_PINS + NUM_EVT;

    wake_src_t           raw_src, sync_src;
    logic [NUM_PINS-1:0] pin_en, pin_pol;
    logic [NUM_EVT-1:0]  evt_en;
    logic                wait_cmd, wake_hit, wait_flag, mck_rdy, run;

    assign raw_src.pin = wk_pin;
    assign raw_src.evt = wk_evt;

    fsw_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_src),
        .q   (sync_src)
    );

    fsw_regs #(.SEL_LAT(SEL_LAT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr_allow  (run),
        .wait_flag (wait_flag),
        .mck_rdy   (mck_rdy),
        .rdata     (bus_rdata),
        .pin_en    (pin_en),
        .pin_pol   (pin_pol),
        .evt_en    (evt_en),
        .xtal_en   (xtal_en),
        .main_sel  (main_src_xtal),
        .wait_cmd  (wait_cmd)
    );

    fsw_wake_detect u_detect (
        .pin     (sync_src.pin),
        .pin_en  (pin_en),
        .pin_pol (pin_pol),
        .evt     (sync_src.evt),
        .evt_en  (evt_en),
        .hit     (wake_hit)
    );

    fsw_pwr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wait_cmd  (wait_cmd),
        .wake_hit  (wake_hit),
        .rc_ready  (rc_ready),
        .clk_en    (clk_en),
        .rc_osc_en (rc_osc_en),
        .wait_flag (wait_flag),
        .mck_rdy   (mck_rdy),
        .run       (run)
    );

    assign wake_req = wake_hit;
endmodule

// File: tb/fsw_ctrl_bench.sv
module fsw_ctrl_bench;
    localparam int SEL_LAT = 3;
    localparam int NVEC    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [10:0] wk_pin = 11'h000;
    logic [4:0]  wk_evt = 5'h00;
    logic        rc_ready = 1'b0;
    logic        clk_en, rc_osc_en, xtal_en, main_src_xtal, wake_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd_v;

    always #4 clk = ~clk;

    fsw_ctrl #(.SEL_LAT(SEL_LAT), .SYNC_STAGES(2)) u_fsw_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wk_pin(wk_pin),
        .wk_evt(wk_evt), .rc_ready(rc_ready), .clk_en(clk_en),
        .rc_osc_en(rc_osc_en), .xtal_en(xtal_en),
        .main_src_xtal(main_src_xtal), .wake_req(wake_req)
    );

    // {enable[31:0], polarity[10:0], pins[10:0], events[4:0], expected wake}
    localparam logic [59:0] VECS [NVEC] = '{
        {32'h0000_0001, 11'h000, 11'h7FE, 5'h00, 1'b1},
        {32'h0000_0001, 11'h000, 11'h7FF, 5'h00, 1'b0},
        {32'h0000_0400, 11'h400, 11'h400, 5'h00, 1'b1},
        {32'h0000_0400, 11'h400, 11'h000, 5'h00, 1'b0},
        {32'h0000_0000, 11'h000, 11'h000, 5'h1F, 1'b0},
        {32'h0002_0000, 11'h000, 11'h7FF, 5'h01, 1'b1},
        {32'h0200_0000, 11'h000, 11'h7FF, 5'h10, 1'b1},
        {32'h0100_0000, 11'h000, 11'h7FF, 5'h10, 1'b0},
        {32'h0008_0000, 11'h000, 11'h7FF, 5'h04, 1'b1},
        {32'h0000_07FF, 11'h7FF, 11'h000, 5'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 clk_en", {31'h0, clk_en}, 32'h1);
        check("R11 rc_osc_en", {31'h0, rc_osc_en}, 32'h1);
        rd(8'h10, rd_v); check("R11 ctrl", rd_v, 32'h0);
        rd(8'h14, rd_v); check("R11 status", rd_v, 32'h3);
        rd(8'h70, rd_v); check("R11 enable", rd_v, 32'h0);
        rd(8'h74, rd_v); check("R11 polarity", rd_v, 32'h0);

        // R3 / R4 field masking
        wr(8'h70, 32'hFFFF_FFFF);
        rd(8'h70, rd_v); check("R3 enable mask", rd_v, 32'h030E_07FF);
        wr(8'h74, 32'hFFFF_FFFF);
        rd(8'h74, rd_v); check("R4 polarity mask", rd_v, 32'h0000_07FF);

        // R5 table of wake patterns (also R3 event bit positions, R4 polarity)
        for (int i = 0; i < NVEC; i++) begin
            wr(8'h70, VECS[i][59:28]);
            wr(8'h74, {21'h0, VECS[i][27:17]});
            @(negedge clk);
            wk_pin = VECS[i][16:6];
            wk_evt = VECS[i][5:1];
            repeat (2) @(negedge clk);
            check($sformatf("R5 vector %0d", i), {31'h0, wake_req}, {31'h0, VECS[i][0]});
        end
        wk_evt = 5'h00;

        // R1 wrong key
        wr(8'h10, 32'h0136_0005);
        rd(8'h10, rd_v); check("R1 bad key ignored", rd_v, 32'h0);
        check("R1 clock kept", {31'h0, clk_en}, 32'h1);

        // R9 source select and crystal enable
        wr(8'h10, 32'h0137_0001);
        check("R9 xtal_en", {31'h0, xtal_en}, 32'h1);
        check("R9 main_src_xtal", {31'h0, main_src_xtal}, 32'h1);
        rd(8'h14, rd_v); check("R9 select pending", rd_v & 32'h1, 32'h0);
        repeat (SEL_LAT - 1) @(negedge clk);
        rd(8'h14, rd_v); check("R9 still pending", rd_v & 32'h1, 32'h0);
        @(negedge clk);
        rd(8'h14, rd_v); check("R9 select done", rd_v & 32'h1, 32'h1);

        // R2 enter wait: pin 3 active high, currently low
        wr(8'h70, 32'h0000_0008);
        wr(8'h74, 32'h0000_0008);
        @(negedge clk);
        wk_pin = 11'h000;
        repeat (2) @(negedge clk);
        wr(8'h10, 32'h0137_0005);
        check("R2 clk_en low", {31'h0, clk_en}, 32'h0);
        check("R2 rc_osc_en low", {31'h0, rc_osc_en}, 32'h0);
        rd(8'h10, rd_v); check("R2 ctrl wait bit", rd_v, 32'h0100_0005);
        rd(8'h14, rd_v); check("R2 mck ready cleared", rd_v & 32'h2, 32'h0);

        // R10 write while stopped is ignored
        wr(8'h70, 32'h0000_07FF);
        rd(8'h70, rd_v); check("R10 write ignored", rd_v, 32'h0000_0008);

        // R6 wake from wait
        @(negedge clk);
        wk_pin = 11'h008;
        repeat (2) @(negedge clk);
        check("R6 wake_req", {31'h0, wake_req}, 32'h1);
        check("R6 rc still off", {31'h0, rc_osc_en}, 32'h0);
        @(negedge clk);
        check("R6 rc restarted", {31'h0, rc_osc_en}, 32'h1);
        repeat (3) @(negedge clk);
        check("R6 clock held off", {31'h0, clk_en}, 32'h0);

        // R7 oscillator ready
        rc_ready = 1'b1;
        @(negedge clk);
        rc_ready = 1'b0;
        check("R7 clk_en back", {31'h0, clk_en}, 32'h1);
        rd(8'h10, rd_v); check("R7 wait bit cleared", rd_v, 32'h0100_0001);
        rd(8'h14, rd_v); check("R7 status", rd_v, 32'h3);
        rd(8'h70, rd_v); check("R10 enable unchanged", rd_v, 32'h0000_0008);

        // R8 wait command with wake already active
        wr(8'h10, 32'h0137_0005);
        check("R8 clock kept", {31'h0, clk_en}, 32'h1);
        rd(8'h10, rd_v); check("R8 wait bit", rd_v, 32'h0100_0001);
        repeat (2) @(negedge clk);
        check("R8 clock still on", {31'h0, clk_en}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule